// File: doc/BRIEF.md
# Multichannel sample packet framer

This block turns one frame of 10-bit sample words into a short packet of bytes for a serial transmitter. Channels are taken in pairs. Each pair uses three bytes: the low seven bits of the even channel, the low seven bits of the odd channel, and a shared byte that carries both channels' top three bits. Two header bytes come first. They hold a 6-bit rolling packet number and one auxiliary byte. The auxiliary byte is drawn from one of eight sub-channels in turn: a repeating ASCII identifier, a 4-bit status input, or zero. Bit 7 of every byte is a framing flag. It is set only in the last byte of a packet, so a receiver can find packet boundaries in the byte stream without any other signal.

A single-cycle `frame_start` pulse captures the sample words, the status bits and the header contents. The block then offers the bytes one at a time on a valid/ready handshake. The sample inputs are free to change as soon as they have been captured. The number of channels (2, 4 or 6) is a parameter, and the packet length follows from it.

Top module: `sample_packet_framer`

## Requirements
- R1: A packet is exactly 3*(NCH/2)+2 bytes long: 11 for the default of six channels. `out_valid` falls in the cycle after the last byte is accepted.
- R2: Bit 7 is 1 in the last byte of every packet and 0 in every other byte.
- R3: Byte 0 is {0, packet number[5:0], aux[7]}. Byte 1 is {0, aux[6:0]}.
- R4: For channel pair p (channels 2p and 2p+1), byte 2+3p is {0, even[6:0]}, byte 3+3p is {0, odd[6:0]}, and byte 4+3p is {0, even[9:7], 0, odd[9:7]}. Channel c occupies bits [10c+9:10c] of `samples_in`.
- R5: The auxiliary sub-channel is the packet number modulo 8. Sub-channels other than 0 and 4 send 8'h00.
- R6: Sub-channel 0 sends the next character of "mEEGv1.0" followed by a 0 byte, so nine entries in all. After the 0 has been sent, the sequence starts again at 'm'.
- R7: Sub-channel 4 sends {4'b0, status_in}, with status_in as it was on the accepted `frame_start` cycle.
- R8: The packet number increases by one for each accepted packet and wraps from 63 to 0.
- R9: After reset `out_valid` is 0. The first packet after reset carries packet number 0 and aux 'm' (8'h6D). `frame_start` takes effect from the third clock after `rst_n` rises.
- R10: Sample words are captured on the accepted `frame_start` cycle. Later changes to `samples_in` do not alter the packet.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged.
- R12: A `frame_start` pulse that arrives while a packet is being sent is ignored. It neither alters that packet nor advances the packet number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Single-cycle request to capture and send one packet |
| samples_in | input | 10*NCH | Sample words, channel c in bits [10c+9:10c] |
| status_in | input | 4 | Status bits for auxiliary sub-channel 4 |
| out_data | output | 8 | Current packet byte |
| out_valid | output | 1 | out_data holds a byte for the consumer |
| out_ready | input | 1 | Consumer accepts the byte on this edge |

## Verification
The edge that samples `frame_start` high also raises `out_valid`, with byte 0 already on `out_data`. Each edge on which valid and ready are both high moves to the next byte, and the edge that takes the last byte lowers `out_valid`. The bench drives its inputs on falling edges. At each falling edge it compares `out_data` against its own model before it raises ready, checks held data one cycle into a stall, and checks that valid is low one cycle after the final byte. It sends 80 packets under four ready patterns, so the packet number and the identifier sequence both wrap. Samples take extreme and mixed values, and the inputs are changed, with a spurious start pulse, while packets are in flight.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int SMP_W    = 10;
  localparam int LO_W     = 7;
  localparam int HI_W     = 3;
  localparam int CNT_W    = 6;
  localparam int STAT_W   = 4;
  localparam int SUB_W    = 3;
  localparam int ID_LEN   = 9;
  localparam int ID_IDX_W = $clog2(ID_LEN);

  localparam logic [SUB_W-1:0] SUB_IDENT  = 3'd0;
  localparam logic [SUB_W-1:0] SUB_STATUS = 3'd4;

  // identifier characters, terminating zero included
  function automatic logic [7:0] ident_char(input logic [ID_IDX_W-1:0] i);
    case (i)
      4'd0:    ident_char = 8'h6D;
      4'd1:    ident_char = 8'h45;
      4'd2:    ident_char = 8'h45;
      4'd3:    ident_char = 8'h47;
      4'd4:    ident_char = 8'h76;
      4'd5:    ident_char = 8'h31;
      4'd6:    ident_char = 8'h2E;
      4'd7:    ident_char = 8'h30;
      default: ident_char = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sfr_rst_sync.sv
module sfr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/sfr_seq_ctr.sv
module sfr_seq_ctr
  import sfr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  output logic [CNT_W-1:0]    cnt_q,
  output logic [ID_IDX_W-1:0] id_idx_q
);
  logic [CNT_W-1:0]    cnt_d;
  logic [ID_IDX_W-1:0] id_idx_d;

  always_comb begin
    cnt_d    = cnt_q;
    id_idx_d = id_idx_q;
    if (adv) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q[SUB_W-1:0] == SUB_IDENT) begin
        if (ident_char(id_idx_q) == 8'h00) id_idx_d = '0;
        else                               id_idx_d = id_idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      id_idx_q <= '0;
    end else if (adv) begin
      cnt_q    <= cnt_d;
      id_idx_q <= id_idx_d;
    end
  end
endmodule

// File: rtl/sfr_aux_src.sv
module sfr_aux_src
  import sfr_pkg::*;
(
  input  logic [SUB_W-1:0]    sub_sel,
  input  logic [ID_IDX_W-1:0] id_idx,
  input  logic [STAT_W-1:0]   status,
  output logic [7:0]          aux
);
  always_comb begin
    case (sub_sel)
      SUB_IDENT:  aux = ident_char(id_idx);
      SUB_STATUS: aux = {{(8-STAT_W){1'b0}}, status};
      default:    aux = 8'h00;
    endcase
  end
endmodule

// File: rtl/sfr_byte_pack.sv
module sfr_byte_pack
  import sfr_pkg::*;
#(
  parameter int NCH     = 6,
  parameter int PKT_LEN = 3 * (NCH / 2) + 2,
  parameter int IDX_W   = $clog2(PKT_LEN)
) (
  input  logic [NCH*SMP_W-1:0] smp,
  input  logic [CNT_W-1:0]     pkt_num,
  input  logic [7:0]           aux,
  input  logic [IDX_W-1:0]     idx,
  output logic [7:0]           byte_o
);
  localparam int NPAIR = NCH / 2;

  logic [6:0] body [PKT_LEN];
  logic [6:0] sel;
  logic       last;

  assign body[0] = {pkt_num, aux[7]};
  assign body[1] = aux[6:0];

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic [SMP_W-1:0] ev;
    logic [SMP_W-1:0] od;
    assign ev = smp[(2*p)*SMP_W   +: SMP_W];
    assign od = smp[(2*p+1)*SMP_W +: SMP_W];
    assign body[2+3*p] = ev[LO_W-1:0];
    assign body[3+3*p] = od[LO_W-1:0];
    assign body[4+3*p] = {ev[SMP_W-1:LO_W], 1'b0, od[SMP_W-1:LO_W]};
  end

  always_comb begin
    sel = body[0];
    for (int k = 0; k < PKT_LEN; k++) begin
      if (idx == IDX_W'(k)) sel = body[k];
    end
  end

  assign last   = (idx == IDX_W'(PKT_LEN - 1));
  assign byte_o = {last, sel};
endmodule

// File: rtl/sample_packet_framer.sv
module sample_packet_framer
  import sfr_pkg::*;
#(
  parameter int NCH = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic [NCH*SMP_W-1:0] samples_in,
  input  logic [STAT_W-1:0]    status_in,
  output logic [7:0]           out_data,
  output logic                 out_valid,
  input  logic                 out_ready
);
  localparam int PKT_LEN = 3 * (NCH / 2) + 2;
  localparam int IDX_W   = $clog2(PKT_LEN);

  logic                 rst_int_n;
  logic                 accept;
  logic                 beat;
  logic                 at_last;
  logic [CNT_W-1:0]     cnt_q;
  logic [ID_IDX_W-1:0]  id_idx_q;
  logic [7:0]           aux_now;

  logic                 vld_q, vld_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [NCH*SMP_W-1:0] smp_q;
  logic [CNT_W-1:0]     pnum_q;
  logic [7:0]           aux_q;

  sfr_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  sfr_seq_ctr u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .adv      (accept),
    .cnt_q    (cnt_q),
    .id_idx_q (id_idx_q)
  );

  sfr_aux_src u_aux (
    .sub_sel (cnt_q[SUB_W-1:0]),
    .id_idx  (id_idx_q),
    .status  (status_in),
    .aux     (aux_now)
  );

  assign accept  = frame_start && !vld_q;
  assign beat    = vld_q && out_ready;
  assign at_last = (idx_q == IDX_W'(PKT_LEN - 1));

  always_comb begin
    vld_d = vld_q;
    idx_d = idx_q;
    if (accept) begin
      vld_d = 1'b1;
      idx_d = '0;
    end else if (beat) begin
      if (at_last) vld_d = 1'b0;
      else         idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q <= 1'b0;
      idx_q <= '0;
    end else begin
      vld_q <= vld_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      smp_q  <= '0;
      pnum_q <= '0;
      aux_q  <= '0;
    end else if (accept) begin
      smp_q  <= samples_in;
      pnum_q <= cnt_q;
      aux_q  <= aux_now;
    end
  end

  sfr_byte_pack #(
    .NCH     (NCH),
    .PKT_LEN (PKT_LEN),
    .IDX_W   (IDX_W)
  ) u_pack (
    .smp     (smp_q),
    .pkt_num (pnum_q),
    .aux     (aux_q),
    .idx     (idx_q),
    .byte_o  (out_data)
  );

  assign out_valid = vld_q;
endmodule

// File: rtl/sfr_chk.sv
module sfr_chk #(
  parameter int NCH = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready
);
  localparam int PKT_LEN = 3 * (NCH / 2) + 2;
  localparam int BW      = $clog2(PKT_LEN + 1);

  logic [BW-1:0] beats_q;
  logic [5:0]    pkts_q;
  logic          vld_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beats_q    <= '0;
      pkts_q     <= '0;
      vld_prev_q <= 1'b0;
    end else begin
      vld_prev_q <= out_valid;
      if (out_valid && !vld_prev_q) pkts_q <= pkts_q + 1'b1;
      if (out_valid && out_ready) begin
        if (beats_q == BW'(PKT_LEN - 1)) beats_q <= '0;
        else                             beats_q <= beats_q + 1'b1;
      end
    end
  end

  // R11: stalled byte is held
  a_r11_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2: flagged byte closes the packet
  a_r2_flag_ends_packet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_data[7]) |=> !out_valid);

  // R1: flag appears on exactly the last counted byte
  a_r1_packet_length: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> (out_data[7] == (beats_q == BW'(PKT_LEN - 1))));

  // R8: header carries packets-seen count
  a_r8_packet_number: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !vld_prev_q) |-> (out_data[6:1] == pkts_q));

  // R1: valid only drops after a handshake
  a_r1_no_early_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
endmodule

bind sample_packet_framer sfr_chk #(.NCH(NCH)) u_sfr_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_ready (out_ready)
);

// File: tb/test_sample_packet_framer.sv
module test_sample_packet_framer;
  localparam int NCH     = 6;
  localparam int PKT_LEN = 3 * (NCH / 2) + 2;
  localparam int NPKT    = 80;

  logic            clk;
  logic            rst_n;
  logic            frame_start;
  logic [NCH*10-1:0] samples_in;
  logic [3:0]      status_in;
  logic [7:0]      out_data;
  logic            out_valid;
  logic            out_ready;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [7:0] exp_b [PKT_LEN];
  int cnt_m = 0;
  int id_m  = 0;
  logic [7:0] lfsr = 8'hA5;

  sample_packet_framer #(.NCH(NCH)) i_sample_packet_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .samples_in  (samples_in),
    .status_in   (status_in),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .out_ready   (out_ready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] id_at(input int i);
    string s;
    s = "mEEGv1.0";
    if (i < 8) return s[i];
    return 8'h00;
  endfunction

  function automatic string tag_of(input int k, input int pk);
    if (k == 0 && pk == 0) return "R9 R3 R8";
    if (k == 0) return "R3 R8 R12";
    if (k == 1) return "R5 R6 R7";
    if (k == PKT_LEN - 1) return "R2 R4 R10";
    return "R4 R10";
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic build(input int pk, output logic [NCH*10-1:0] smp, output logic [3:0] st);
    logic [7:0] aux;
    int v;
    for (int ch = 0; ch < NCH; ch++) begin
      if (pk == 1)      v = 1023;
      else if (pk == 2) v = 0;
      else if (pk == 3) v = (ch % 2 == 0) ? 10'h2AA : 10'h155;
      else              v = (pk * 37 + ch * 151 + ((pk % 5 == 0) ? 512 : 0)) % 1024;
      smp[ch*10 +: 10] = 10'(v);
    end
    st = 4'(pk) ^ 4'h9;
    case (cnt_m % 8)
      0: begin
        aux = id_at(id_m);
        id_m = (aux == 8'h00) ? 0 : id_m + 1;
      end
      4: aux = {4'h0, st};
      default: aux = 8'h00;
    endcase
    exp_b[0] = 8'(((cnt_m % 64) << 1) | int'(aux >> 7));
    exp_b[1] = aux & 8'h7F;
    for (int p = 0; p < NCH / 2; p++) begin
      logic [9:0] ev, od;
      ev = smp[(2*p)*10 +: 10];
      od = smp[(2*p+1)*10 +: 10];
      exp_b[2+3*p] = {1'b0, ev[6:0]};
      exp_b[3+3*p] = {1'b0, od[6:0]};
      exp_b[4+3*p] = {1'b0, ev[9:7], 1'b0, od[9:7]};
    end
    exp_b[PKT_LEN-1] = exp_b[PKT_LEN-1] | 8'h80;
    cnt_m++;
  endtask

  initial begin
    logic [NCH*10-1:0] smp;
    logic [3:0] st;
    logic [7:0] held;
    bit pend;
    bit rdy;
    int k;
    int wait_n;
    rst_n       = 1'b0;
    frame_start = 1'b0;
    samples_in  = '0;
    status_in   = '0;
    out_ready   = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R9 valid after reset", int'(out_valid), 0);

    for (int pk = 0; pk < NPKT; pk++) begin
      build(pk, smp, st);
      samples_in  = smp;
      status_in   = st;
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      samples_in  = ~smp;   // R10: must not reach the packet
      status_in   = ~st;    // R7: captured value only
      k = 0;
      pend = 0;
      wait_n = 0;
      while (k < PKT_LEN && wait_n < 200) begin
        frame_start = 1'b0;
        wait_n++;
        if (pend) begin
          chk(out_valid && out_data == held, "R11 stall hold", int'(out_data), int'(held));
          pend = 0;
        end
        if (!out_valid) begin
          chk(1'b0, "R1 valid dropped early", k, PKT_LEN);
          k = PKT_LEN;
        end else begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          case (pk % 4)
            0: rdy = 1'b1;
            1: rdy = (wait_n % 2 == 0);
            2: rdy = (wait_n % 3 == 2);
            default: rdy = lfsr[0];
          endcase
          out_ready = rdy;
          if (rdy) begin
            chk(out_data == exp_b[k], tag_of(k, pk), int'(out_data), int'(exp_b[k]));
            chk(out_data[7] == (k == PKT_LEN - 1), "R2 sync flag", int'(out_data[7]),
                int'(k == PKT_LEN - 1));
            k++;
          end else begin
            held = out_data;
            pend = 1;
          end
          if (pk % 3 == 1 && k == 3) frame_start = 1'b1;  // R12: ignored
        end
        @(negedge clk);
      end
      frame_start = 1'b0;
      out_ready   = 1'b0;
      chk(out_valid == 1'b0, "R1 end of packet", int'(out_valid), 0);
      @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule